// File: doc/BRIEF.md
# Receive Datapath Sample Tap Window

This block gives a host a byte-wide view of the 16-bit in-phase (I) and quadrature (Q) samples at one point of a receive datapath, the point just after the decimating anti-alias filter. The host reaches the samples through four 8-bit locations on a small synchronous bus. A read of a channel's low byte also copies that channel's high byte into a shadow register. A following read of the high byte returns the shadow copy, so the two halves always belong to the same sample period even if new samples arrive between the two reads.

The host can also inject samples. A byte write replaces one half of the stored 16-bit value for that channel. While the injection select input is high, the stored values drive the tap outputs toward the rest of the datapath, and live samples no longer overwrite them. While the select is low, the stored values follow the live samples on every sample strobe, and the tap outputs pass the live samples straight through.

Top module: `smp_tap_window`

## Requirements
- R1: The window sits at byte addresses BASE_ADDR+0 to BASE_ADDR+3 (default 0x38 to 0x3B). These map, in address order, to I bits [7:0], I bits [15:8], Q bits [7:0] and Q bits [15:8].
- R2: Read data is registered. `bus_rdata` carries the addressed byte in the cycle after `bus_rd` is sampled high, and is 0 in the cycle after a cycle with `bus_rd` low.
- R3: Reading a low-byte address returns bits [7:0] of that channel's stored value and copies bits [15:8] into that channel's shadow. Reading the high-byte address returns the shadow, not the stored high byte.
- R4: A channel's shadow changes only on a read of that channel's low byte. Samples and writes that arrive between the low read and the high read do not alter the value the high read returns.
- R5: The I and Q shadows are independent. A low-byte read of one channel leaves the other channel's shadow unchanged.
- R6: With `inj_sel` low, a cycle with `smp_vld` high and no host write to the channel loads `live_i` and `live_q` into the stored values.
- R7: With `inj_sel` high, `smp_vld` has no effect on the stored values.
- R8: A host write changes only the addressed byte of the stored value. A write to a channel takes precedence over a sample strobe in the same cycle, and the live sample is then dropped for that channel.
- R9: `tap_i` and `tap_q` equal the stored values while `inj_sel` is high, and equal `live_i` and `live_q` while it is low.
- R10: A synchronous active-low reset clears the stored values, the shadows and `bus_rdata` to 0.
- R11: A read or write at an address outside the window changes no stored value or shadow, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| smp_vld | input | 1 | One-cycle strobe marking a new live sample |
| live_i | input | 16 | Live I sample from the filter |
| live_q | input | 16 | Live Q sample from the filter |
| inj_sel | input | 1 | High: stored values drive the taps, and samples are blocked |
| tap_i | output | 16 | I value driven onward at the tap point |
| tap_q | output | 16 | Q value driven onward at the tap point |

## Verification
On every cycle, the assertions check the following:
- The shadow holds its value outside low-byte reads.
- Stored values stay frozen while injection is selected.
- A byte write leaves the other half of the value intact.
- A sample strobe loads the live value when nothing blocks it.
- At most one window slot is decoded at a time.
- Read data returns to 0 after an idle cycle.

Only the bench scenarios can show the points that depend on order and data:
- The high-byte read returns the half captured earlier, even after fresh samples have arrived.
- The two channels' shadows stay apart when reads are interleaved.
- A write beats a sample strobe that arrives in the same cycle.
- Addresses just outside the window leave every stored value untouched.

// File: rtl/smp_tap_pkg.sv
// Shared types for the sample tap window.
// Assumes two channels (I and Q), each split into a low byte and a high byte.
package smp_tap_pkg;

    localparam int NCH = 2;

    // Slot order inside the window; the address decode depends on this order.
    typedef enum logic [1:0] {
        SLOT_I_LO = 2'd0,
        SLOT_I_HI = 2'd1,
        SLOT_Q_LO = 2'd2,
        SLOT_Q_HI = 2'd3
    } slot_e;

    // Per-channel access strobes produced by the address decode.
    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
    } chan_strb_t;

endpackage

// File: rtl/smp_bus_decode.sv
// Address decode for the sample tap window.
// What it does: turns address, read and write into one strobe set per channel.
// Assumes: the window is 2*NCH bytes starting at BASE_ADDR, with a low byte
// then a high byte for each channel in turn. Outside the window, no strobe fires.
module smp_bus_decode
    import smp_tap_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          CHANNELS  = NCH,
    parameter logic [7:0]  BASE_ADDR = 8'h38
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  logic                        rd,
    output chan_strb_t [CHANNELS-1:0]   strb
);

    localparam int SPAN = 2 * CHANNELS;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    logic [ADDR_W-1:0] offset;
    logic              in_win;

    // Offset from the window base, and the window hit.
    always_comb begin
        offset = addr - BASE;
        in_win = (addr >= BASE) && (offset < ADDR_W'(SPAN));
    end

    // One strobe set per channel: the even offset is the low byte, the odd offset the high byte.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        localparam logic [ADDR_W-1:0] LO_OFF = ADDR_W'(2 * c);
        localparam logic [ADDR_W-1:0] HI_OFF = ADDR_W'(2 * c + 1);
        always_comb begin
            strb[c].rd_lo = rd && in_win && (offset == LO_OFF);
            strb[c].rd_hi = rd && in_win && (offset == HI_OFF);
            strb[c].wr_lo = wr && in_win && (offset == LO_OFF);
            strb[c].wr_hi = wr && in_win && (offset == HI_OFF);
        end
    end

endmodule

// File: rtl/smp_chan_store.sv
// Storage for one channel: the stored sample, the high-byte shadow and the tap select.
// What it does: loads live samples unless injection is selected. Host byte writes
// take precedence over a sample in the same cycle. A low-byte read copies the
// high byte into the shadow.
// Assumes: SMP_W is exactly two bytes wide, and the strobes come from smp_bus_decode.
module smp_chan_store
    import smp_tap_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  chan_strb_t         strb,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               smp_vld,
    input  logic [SMP_W-1:0]   live,
    input  logic               inj_sel,
    output logic [SMP_W-1:0]   tap,
    output logic [BYTE_W-1:0]  rd_byte
);

    localparam int HI_LSB = SMP_W - BYTE_W;

    logic [SMP_W-1:0]  val_q;
    logic [BYTE_W-1:0] shadow_q;
    logic              host_wr;

    // Any host write to this channel.
    always_comb host_wr = strb.wr_lo || strb.wr_hi;

    // Stored value: a host byte write wins, otherwise the live sample when not injecting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (host_wr) begin
            if (strb.wr_lo) val_q[BYTE_W-1:0]     <= wdata;
            if (strb.wr_hi) val_q[SMP_W-1:HI_LSB] <= wdata;
        end else if (smp_vld && !inj_sel) begin
            val_q <= live;
        end
    end

    // Shadow: copy of the high byte, taken on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (strb.rd_lo) begin
            shadow_q <= val_q[SMP_W-1:HI_LSB];
        end
    end

    // Tap output and the byte offered to the read mux.
    always_comb begin
        tap = inj_sel ? val_q : live;
        if (strb.rd_lo)      rd_byte = val_q[BYTE_W-1:0];
        else if (strb.rd_hi) rd_byte = shadow_q;
        else                 rd_byte = '0;
    end

    AST_SEL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_sel && !host_wr) |=> $stable(val_q)); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.rd_lo |=> $stable(shadow_q)); // R4

    AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !inj_sel && !host_wr) |=> (val_q == $past(live))); // R6

    AST_WR_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.wr_lo && !strb.wr_hi) |=> (val_q[SMP_W-1:HI_LSB] == $past(val_q[SMP_W-1:HI_LSB]))); // R8

    AST_WR_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.wr_hi && !strb.wr_lo) |=> (val_q[BYTE_W-1:0] == $past(val_q[BYTE_W-1:0]))); // R8

    AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        strb.rd_lo |=> (shadow_q == $past(val_q[SMP_W-1:HI_LSB]))); // R3

endmodule

// File: rtl/smp_tap_window.sv
// Top of the sample tap window.
// What it does: decodes the four-byte host window, keeps one store per channel,
// registers the read data and drives the I and Q tap outputs.
// Assumes: the host reads the low byte before the high byte to get a coherent
// sample, and only one slot is accessed per cycle.
module smp_tap_window
    import smp_tap_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          BYTE_W    = 8,
    parameter int          SMP_W     = 16,
    parameter logic [7:0]  BASE_ADDR = 8'h38
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic               smp_vld,
    input  logic [SMP_W-1:0]   live_i,
    input  logic [SMP_W-1:0]   live_q,
    input  logic               inj_sel,
    output logic [SMP_W-1:0]   tap_i,
    output logic [SMP_W-1:0]   tap_q
);

    chan_strb_t [NCH-1:0]         strb;
    logic [NCH-1:0][SMP_W-1:0]    live_v;
    logic [NCH-1:0][SMP_W-1:0]    tap_v;
    logic [NCH-1:0][BYTE_W-1:0]   byte_v;
    logic [BYTE_W-1:0]            rd_mux;
    logic [4*NCH-1:0]             all_strb;

    // Gather the live samples into channel order (0 = I, 1 = Q).
    always_comb begin
        live_v[0] = live_i;
        live_v[1] = live_q;
    end

    smp_bus_decode #(
        .ADDR_W    (ADDR_W),
        .CHANNELS  (NCH),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .strb (strb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_store
        smp_chan_store #(
            .SMP_W  (SMP_W),
            .BYTE_W (BYTE_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .strb    (strb[c]),
            .wdata   (bus_wdata),
            .smp_vld (smp_vld),
            .live    (live_v[c]),
            .inj_sel (inj_sel),
            .tap     (tap_v[c]),
            .rd_byte (byte_v[c])
        );
    end

    // Read mux: at most one channel offers a non-zero byte, so OR them together.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) rd_mux = rd_mux | byte_v[c];
        tap_i    = tap_v[0];
        tap_q    = tap_v[1];
        all_strb = strb;
    end

    // Registered read data: the addressed byte after a read, otherwise 0.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_rd ? rd_mux : '0;
    end

    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_strb)); // R1

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R2

endmodule

// File: tb/sim_smp_tap_window.sv
// Bench for smp_tap_window: a behavioural reference model is compared on every
// negative clock edge, and directed scenarios check each requirement.
module sim_smp_tap_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        smp_vld = 1'b0;
    logic [15:0] live_i = '0;
    logic [15:0] live_q = '0;
    logic        inj_sel = 1'b0;
    logic [15:0] tap_i;
    logic [15:0] tap_q;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit done = 0;

    // Reference model state
    int m_val [2];
    int m_sh  [2];
    int m_rd;

    always #2ns clk = ~clk;

    smp_tap_window u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_vld(smp_vld), .live_i(live_i), .live_q(live_q), .inj_sel(inj_sel),
        .tap_i(tap_i), .tap_q(tap_q)
    );

    // Reference model: read first (it sees the old value), then write or sample.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_val[0] = 0; m_val[1] = 0; m_sh[0] = 0; m_sh[1] = 0; m_rd = 0;
        end else begin
            int off;
            off = int'(bus_addr) - 'h38;
            m_rd = 0;
            if (bus_rd && off >= 0 && off < 4) begin
                if (off % 2 == 0) begin
                    m_rd = m_val[off/2] % 256;
                    m_sh[off/2] = m_val[off/2] / 256;
                end else begin
                    m_rd = m_sh[off/2];
                end
            end
            for (int ch = 0; ch < 2; ch++) begin
                bit hit;
                hit = bus_wr && off >= 0 && off < 4 && (off / 2 == ch);
                if (hit) begin
                    if (off % 2 == 0) m_val[ch] = (m_val[ch] / 256) * 256 + int'(bus_wdata);
                    else              m_val[ch] = int'(bus_wdata) * 256 + m_val[ch] % 256;
                end else if (smp_vld && !inj_sel) begin
                    m_val[ch] = (ch == 0) ? int'(live_i) : int'(live_q);
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 per-cycle read data", int'(bus_rdata), m_rd);
            chk("R9 per-cycle tap_i", int'(tap_i), inj_sel ? m_val[0] : int'(live_i));
            chk("R9 per-cycle tap_q", int'(tap_q), inj_sel ? m_val[1] : int'(live_q));
        end
    end

    task automatic tick;
        @(posedge clk);
        #1ns;
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick;
        bus_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        tick;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic sample(input logic [15:0] i, input logic [15:0] q);
        live_i = i; live_q = q; smp_vld = 1'b1;
        tick;
        smp_vld = 1'b0;
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            summary;
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick; tick;
        rst_n = 1'b1;
        tick;
        // R10: reset state
        chk("R10 rdata after reset", int'(bus_rdata), 0);
        hread(8'h38, d); chk("R10 I low after reset", int'(d), 0);
        hread(8'h3B, d); chk("R10 Q high after reset", int'(d), 0);

        // R6, R3, R4: load a sample, then read coherently across a newer sample
        sample(16'hA1B2, 16'hC3D4);
        hread(8'h38, d); chk("R6 R3 I low", int'(d), 'hB2);
        sample(16'h5566, 16'h7788);
        hread(8'h39, d); chk("R4 I high from shadow", int'(d), 'hA1);
        hread(8'h3A, d); chk("R6 Q low", int'(d), 'h88);
        hread(8'h3B, d); chk("R3 Q high", int'(d), 'h77);

        // R5: interleaved channel reads keep separate shadows
        hread(8'h38, d); chk("R5 I low", int'(d), 'h66);
        hread(8'h3A, d); chk("R5 Q low", int'(d), 'h88);
        hread(8'h39, d); chk("R5 I high unaffected by Q read", int'(d), 'h55);

        // R8, R9, R7: injection under select
        inj_sel = 1'b1;
        hwrite(8'h38, 8'h11);
        hwrite(8'h39, 8'h22);
        chk("R9 tap_i injected", int'(tap_i), 'h2211);
        sample(16'hFFFF, 16'hFFFF);
        chk("R7 tap_i after blocked sample", int'(tap_i), 'h2211);
        hread(8'h38, d); chk("R7 I low unchanged", int'(d), 'h11);
        hwrite(8'h3B, 8'h99);
        chk("R1 R8 Q high byte only", int'(tap_q), 'h9988);
        hread(8'h3A, d); chk("R8 Q low kept", int'(d), 'h88);
        hread(8'h3B, d); chk("R8 Q high written", int'(d), 'h99);
        inj_sel = 1'b0;

        // R8: a write beats a simultaneous sample strobe
        live_i = 16'hABCD; smp_vld = 1'b1;
        bus_addr = 8'h38; bus_wdata = 8'h5A; bus_wr = 1'b1;
        tick;
        smp_vld = 1'b0; bus_wr = 1'b0;
        hread(8'h38, d); chk("R8 collision low byte", int'(d), 'h5A);
        hread(8'h39, d); chk("R8 collision high kept", int'(d), 'h22);

        // R9: pass-through when not injecting
        live_i = 16'h1357; live_q = 16'h2468;
        #1ns;
        chk("R9 tap_i pass", int'(tap_i), 'h1357);
        chk("R9 tap_q pass", int'(tap_q), 'h2468);

        // R11: accesses outside the window have no effect
        hwrite(8'h3C, 8'hFF);
        hwrite(8'h37, 8'hFF);
        hread(8'h38, d); chk("R11 I low untouched", int'(d), 'h5A);
        hread(8'h39, d); chk("R11 I high untouched", int'(d), 'h22);
        hread(8'h3C, d); chk("R11 read outside returns 0", int'(d), 0);

        // R2: an idle cycle returns read data to 0
        tick;
        chk("R2 rdata idle", int'(bus_rdata), 0);

        // R10: reset in mid-run clears everything
        rst_n = 1'b0; tick;
        rst_n = 1'b1; tick;
        hread(8'h38, d); chk("R10 I low cleared", int'(d), 0);
        hread(8'h39, d); chk("R10 I shadow cleared", int'(d), 0);
        inj_sel = 1'b1; #1ns;
        chk("R10 tap_q cleared", int'(tap_q), 0);
        tick;

        done = 1;
        summary;
        $finish;
    end

endmodule